// File: doc/BRIEF.md
# Keyboard Controller Host Command Engine

This block is the host-side register engine of a PC-style keyboard controller. A host reaches it over a byte-wide write bus. One address bit selects either the data port or the command port. A read of the command port returns the status register, which is presented continuously on `status_o`. The engine holds three registers: the mode register, the status register and the output-port register. The output-port register drives the gate-A20 line and can request a system reset. A separate fast port also writes the output-port register directly.

Command bytes act in one of two ways. Some act at once: they change a register, or they push a reply byte into the reply queue, tagged as keyboard-side or auxiliary-side. Others arm the engine, and the next data-port write supplies their operand. A data-port write that arrives while no command is armed goes to the keyboard. Bytes bound for the keyboard or the mouse leave on plain valid/data strobes. Reply pushes and device strobes appear combinationally, in the same cycle as the accepted write. Register changes are visible from the next cycle.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset, mode reads 0x03, status reads 0x18, the output port reads 0x03 and A20 is high. No command is armed and no strobe or reset request is active.
- R2: In the same cycle as the command, a reply is pushed with the source tag low (keyboard side), as follows:
  - command 0x20 pushes the mode register;
  - command 0xAA pushes 0x55 and sets status bit 2 from the next cycle;
  - commands 0xA9, 0xAB and 0xC0 push 0x00;
  - command 0xD0 pushes the output-port register.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm the engine. The next data-port write executes the armed action and disarms the engine.
- R4: A data-port write with nothing armed raises `kbd_tx_valid` for that cycle with the written byte.
- R5: Each armed command acts on the next data byte:
  - after 0xD2, the byte is pushed as a reply with the tag low;
  - after 0xD3, the byte is pushed as a reply with the tag high (auxiliary side);
  - after 0xD4, the byte leaves on `mouse_tx_valid`/`mouse_tx_data`.
- R6: Commands change the mode register as follows:
  - 0xA7 sets mode bit 5 and 0xA8 clears it;
  - 0xAD sets mode bit 4 and 0xAE clears it;
  - an operand written after 0x60 replaces the whole mode register, and `xlate_o` follows mode bit 6.
- R7: Command 0xDF sets output-port bit 1 and command 0xDD clears it. `a20_o` always equals output-port bit 1.
- R8: An operand after 0xD1, or a fast-port write, replaces the output port. A fast-port write wins over a concurrent operand write. Writing bit 0 as zero requests a system reset.
- R9: Any command with upper nibble 0xF is remapped before it is decoded. With bit 0 clear it acts as 0xFE and requests a reset. With bit 0 set it acts as 0xFF and does nothing.
- R10: Command codes not listed above change no register and produce no strobe. A non-arming command leaves an armed command in place.
- R11: `sys_rst_o` rises in the cycle after the requesting write and lasts exactly one cycle for each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 1 | 0 = data port, 1 = command port |
| bus_wdata | input | 8 | Host write byte |
| fast_wr | input | 1 | Fast output-port write strobe |
| fast_wdata | input | 8 | Fast output-port byte |
| status_o | output | 8 | Status register (command-port read value) |
| mode_o | output | 8 | Mode register |
| outport_o | output | 8 | Output-port register |
| a20_o | output | 1 | Gate-A20 line |
| xlate_o | output | 1 | Scancode translation enable |
| sys_rst_o | output | 1 | One-cycle system reset request |
| reply_valid | output | 1 | Reply queue push |
| reply_data | output | 8 | Reply byte |
| reply_aux | output | 1 | Reply source tag, 1 = auxiliary |
| kbd_tx_valid | output | 1 | Byte to keyboard valid |
| kbd_tx_data | output | 8 | Byte to keyboard |
| mouse_tx_valid | output | 1 | Byte to mouse valid |
| mouse_tx_data | output | 8 | Byte to mouse |

## Verification
A wrong armed-command state cannot be seen until the next data-port write. That write then takes the wrong path, so the byte appears on the wrong strobe, on the wrong reply tag, or in the wrong register. For this reason the bench always follows an arming command with an operand write and checks the strobes in that same cycle. Corrupted mode, status or output-port bits show one cycle after the faulty write, because the bench compares all three registers, A20, the translation flag and the reset pulse against its model on every clock. A misdecoded 0xF-range remap shows as a missing or extra reset pulse in the following cycle.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    localparam int unsigned BW = 8;
    typedef logic [BW-1:0] byte_t;

    typedef struct packed {
        byte_t mode;
        byte_t status;
        byte_t outport;
        byte_t pend;
        logic  rst;
    } kbc_state_t;

    localparam byte_t C_RD_MODE   = 8'h20;
    localparam byte_t C_WR_MODE   = 8'h60;
    localparam byte_t C_AUX_OFF   = 8'hA7;
    localparam byte_t C_AUX_ON    = 8'hA8;
    localparam byte_t C_AUX_TEST  = 8'hA9;
    localparam byte_t C_SELF      = 8'hAA;
    localparam byte_t C_KBD_TEST  = 8'hAB;
    localparam byte_t C_KBD_OFF   = 8'hAD;
    localparam byte_t C_KBD_ON    = 8'hAE;
    localparam byte_t C_RD_IN     = 8'hC0;
    localparam byte_t C_RD_OUT    = 8'hD0;
    localparam byte_t C_WR_OUT    = 8'hD1;
    localparam byte_t C_WR_KOB    = 8'hD2;
    localparam byte_t C_WR_AOB    = 8'hD3;
    localparam byte_t C_WR_AUX    = 8'hD4;
    localparam byte_t C_GATE_OFF  = 8'hDD;
    localparam byte_t C_GATE_ON   = 8'hDF;
    localparam byte_t C_PULSE_RST = 8'hFE;
    localparam byte_t C_NOP       = 8'hFF;

    localparam int unsigned M_KBD_DIS  = 4;
    localparam int unsigned M_AUX_DIS  = 5;
    localparam int unsigned M_XLATE    = 6;
    localparam int unsigned S_SELFTEST = 2;
    localparam int unsigned O_NRST     = 0;
    localparam int unsigned O_GATE     = 1;
endpackage

// File: rtl/kbc_cmd_remap.sv
module kbc_cmd_remap
    import kbc_pkg::*;
(
    input  byte_t raw_i,
    output byte_t cmd_o
);
    localparam int unsigned NIB = BW / 2;

    always_comb begin
        if (raw_i[BW-1 -: NIB] == {NIB{1'b1}}) begin
            cmd_o = raw_i[0] ? C_NOP : C_PULSE_RST;
        end else begin
            cmd_o = raw_i;
        end
    end
endmodule

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  byte_t      cmd_i,
    input  kbc_state_t cur_i,
    output kbc_state_t nxt_o,
    output logic       push_o,
    output byte_t      push_data_o
);
    always_comb begin
        nxt_o       = cur_i;
        nxt_o.rst   = 1'b0;
        push_o      = 1'b0;
        push_data_o = '0;
        case (cmd_i)
            C_RD_MODE: begin
                push_o      = 1'b1;
                push_data_o = cur_i.mode;
            end
            C_WR_MODE, C_WR_OUT, C_WR_KOB, C_WR_AOB, C_WR_AUX:
                nxt_o.pend = cmd_i;
            C_AUX_OFF: nxt_o.mode[M_AUX_DIS] = 1'b1;
            C_AUX_ON:  nxt_o.mode[M_AUX_DIS] = 1'b0;
            C_KBD_OFF: nxt_o.mode[M_KBD_DIS] = 1'b1;
            C_KBD_ON:  nxt_o.mode[M_KBD_DIS] = 1'b0;
            C_AUX_TEST, C_KBD_TEST, C_RD_IN: push_o = 1'b1;
            C_SELF: begin
                nxt_o.status[S_SELFTEST] = 1'b1;
                push_o      = 1'b1;
                push_data_o = 8'h55;
            end
            C_RD_OUT: begin
                push_o      = 1'b1;
                push_data_o = cur_i.outport;
            end
            C_GATE_ON:   nxt_o.outport[O_GATE] = 1'b1;
            C_GATE_OFF:  nxt_o.outport[O_GATE] = 1'b0;
            C_PULSE_RST: nxt_o.rst = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/kbc_data_route.sv
module kbc_data_route
    import kbc_pkg::*;
(
    input  byte_t      data_i,
    input  kbc_state_t cur_i,
    output kbc_state_t nxt_o,
    output logic       push_o,
    output logic       push_aux_o,
    output logic       ktx_o,
    output logic       mtx_o
);
    always_comb begin
        nxt_o      = cur_i;
        nxt_o.rst  = 1'b0;
        nxt_o.pend = '0;
        push_o     = 1'b0;
        push_aux_o = 1'b0;
        ktx_o      = 1'b0;
        mtx_o      = 1'b0;
        case (cur_i.pend)
            C_WR_MODE: nxt_o.mode = data_i;
            C_WR_KOB:  push_o = 1'b1;
            C_WR_AOB: begin
                push_o     = 1'b1;
                push_aux_o = 1'b1;
            end
            C_WR_OUT: begin
                nxt_o.outport = data_i;
                nxt_o.rst     = ~data_i[O_NRST];
            end
            C_WR_AUX: mtx_o = 1'b1;
            default:  ktx_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
    import kbc_pkg::*;
#(
    parameter logic [7:0] MODE_RST = 8'h03,
    parameter logic [7:0] STAT_RST = 8'h18,
    parameter logic [7:0] OUT_RST  = 8'h03
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       fast_wr,
    input  logic [7:0] fast_wdata,
    output logic [7:0] status_o,
    output logic [7:0] mode_o,
    output logic [7:0] outport_o,
    output logic       a20_o,
    output logic       xlate_o,
    output logic       sys_rst_o,
    output logic       reply_valid,
    output logic [7:0] reply_data,
    output logic       reply_aux,
    output logic       kbd_tx_valid,
    output logic [7:0] kbd_tx_data,
    output logic       mouse_tx_valid,
    output logic [7:0] mouse_tx_data
);
    kbc_state_t s_q, s_d, cmd_nxt, dat_nxt;
    byte_t      cmd_eff, cmd_push_data;
    logic       cmd_push, dat_push, dat_aux, dat_ktx, dat_mtx;

    kbc_cmd_remap u_remap (.raw_i(bus_wdata), .cmd_o(cmd_eff));

    kbc_cmd_decode u_decode (
        .cmd_i(cmd_eff), .cur_i(s_q), .nxt_o(cmd_nxt),
        .push_o(cmd_push), .push_data_o(cmd_push_data)
    );

    kbc_data_route u_route (
        .data_i(bus_wdata), .cur_i(s_q), .nxt_o(dat_nxt),
        .push_o(dat_push), .push_aux_o(dat_aux),
        .ktx_o(dat_ktx), .mtx_o(dat_mtx)
    );

    always_comb begin
        s_d            = s_q;
        s_d.rst        = 1'b0;
        reply_valid    = 1'b0;
        reply_data     = '0;
        reply_aux      = 1'b0;
        kbd_tx_valid   = 1'b0;
        mouse_tx_valid = 1'b0;
        if (bus_wr && bus_addr) begin
            s_d         = cmd_nxt;
            reply_valid = cmd_push;
            reply_data  = cmd_push_data;
        end else if (bus_wr) begin
            s_d            = dat_nxt;
            reply_valid    = dat_push;
            reply_data     = dat_push ? bus_wdata : '0;
            reply_aux      = dat_aux;
            kbd_tx_valid   = dat_ktx;
            mouse_tx_valid = dat_mtx;
        end
        if (fast_wr) begin
            s_d.outport = fast_wdata;
            if (!fast_wdata[O_NRST]) s_d.rst = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{mode: MODE_RST, status: STAT_RST, outport: OUT_RST,
                     pend: '0, rst: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign status_o      = s_q.status;
    assign mode_o        = s_q.mode;
    assign outport_o     = s_q.outport;
    assign a20_o         = s_q.outport[O_GATE];
    assign xlate_o       = s_q.mode[M_XLATE];
    assign sys_rst_o     = s_q.rst;
    assign kbd_tx_data   = bus_wdata;
    assign mouse_tx_data = bus_wdata;

    p_fast_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fast_wr |=> outport_o == $past(fast_wdata));

    p_rst_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> $past(bus_wr || fast_wr));

    p_selftest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && bus_wdata == C_SELF) |=> status_o[S_SELFTEST]);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !fast_wr) |=> ($stable(mode_o) && $stable(outport_o)
                                   && $stable(status_o) && !sys_rst_o));

    p_mouse_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mouse_tx_valid |-> (bus_wr && !bus_addr));

    p_one_sink_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({kbd_tx_valid, mouse_tx_valid, reply_valid}));
endmodule

// File: tb/kbc_cmd_engine_bench.sv
module kbc_cmd_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_addr = 1'b0, fast_wr = 1'b0;
    logic [7:0] bus_wdata = '0, fast_wdata = '0;
    logic [7:0] status_o, mode_o, outport_o, reply_data, kbd_tx_data, mouse_tx_data;
    logic       a20_o, xlate_o, sys_rst_o, reply_valid, reply_aux, kbd_tx_valid, mouse_tx_valid;

    int tests = 0, fails = 0;
    bit chk_en = 1'b0, done = 1'b0;

    // reference model
    int m_mode, m_stat, m_out, m_pend;
    bit m_rst;

    always #5 clk = ~clk;

    kbc_cmd_engine u_kbc_cmd_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .fast_wr(fast_wr), .fast_wdata(fast_wdata),
        .status_o(status_o), .mode_o(mode_o), .outport_o(outport_o),
        .a20_o(a20_o), .xlate_o(xlate_o), .sys_rst_o(sys_rst_o),
        .reply_valid(reply_valid), .reply_data(reply_data), .reply_aux(reply_aux),
        .kbd_tx_valid(kbd_tx_valid), .kbd_tx_data(kbd_tx_data),
        .mouse_tx_valid(mouse_tx_valid), .mouse_tx_data(mouse_tx_data)
    );

    task automatic check(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // registered outputs against the model on every clock
    always @(negedge clk) begin
        if (chk_en) begin
            check("R6", "mode", int'(mode_o), m_mode);
            check("R2", "status", int'(status_o), m_stat);
            check("R8", "outport", int'(outport_o), m_out);
            check("R7", "a20", int'(a20_o), (m_out >> 1) & 1);
            check("R6", "xlate", int'(xlate_o), (m_mode >> 6) & 1);
            check("R11", "sys_rst", int'(sys_rst_o), int'(m_rst));
        end
    end

    task automatic step(string tag, bit bw, bit ba, int bd, bit fw, int fd);
        int  c, e_pv, e_pd, e_pa, e_kt, e_mt;
        int  n_mode, n_stat, n_out, n_pend;
        bit  n_rst;
        @(negedge clk);
        bus_wr = bw; bus_addr = ba; bus_wdata = 8'(bd);
        fast_wr = fw; fast_wdata = 8'(fd);
        n_mode = m_mode; n_stat = m_stat; n_out = m_out; n_pend = m_pend; n_rst = 0;
        e_pv = 0; e_pd = 0; e_pa = 0; e_kt = 0; e_mt = 0;
        if (bw && ba) begin
            c = bd;
            if ((c >> 4) == 'hF) c = (c & 1) ? 'hFF : 'hFE;
            case (c)
                'h20: begin e_pv = 1; e_pd = m_mode; end
                'h60, 'hD1, 'hD2, 'hD3, 'hD4: n_pend = c;
                'hA7: n_mode = m_mode | 'h20;
                'hA8: n_mode = m_mode & 'hDF;
                'hAD: n_mode = m_mode | 'h10;
                'hAE: n_mode = m_mode & 'hEF;
                'hA9, 'hAB, 'hC0: e_pv = 1;
                'hAA: begin n_stat = m_stat | 4; e_pv = 1; e_pd = 'h55; end
                'hD0: begin e_pv = 1; e_pd = m_out; end
                'hDF: n_out = m_out | 2;
                'hDD: n_out = m_out & 'hFD;
                'hFE: n_rst = 1;
                default: ;
            endcase
        end else if (bw) begin
            case (m_pend)
                'h60: n_mode = bd;
                'hD2: begin e_pv = 1; e_pd = bd; end
                'hD3: begin e_pv = 1; e_pd = bd; e_pa = 1; end
                'hD1: begin n_out = bd; n_rst = !(bd & 1); end
                'hD4: e_mt = 1;
                default: e_kt = 1;
            endcase
            n_pend = 0;
        end
        if (fw) begin
            n_out = fd;
            if (!(fd & 1)) n_rst = 1;
        end
        #1;
        check(tag, "reply_valid", int'(reply_valid), e_pv);
        if (e_pv) begin
            check(tag, "reply_data", int'(reply_data), e_pd);
            check(tag, "reply_aux", int'(reply_aux), e_pa);
        end
        check(tag, "kbd_tx_valid", int'(kbd_tx_valid), e_kt);
        if (e_kt) check(tag, "kbd_tx_data", int'(kbd_tx_data), bd);
        check(tag, "mouse_tx_valid", int'(mouse_tx_valid), e_mt);
        if (e_mt) check(tag, "mouse_tx_data", int'(mouse_tx_data), bd);
        @(posedge clk);
        m_mode = n_mode; m_stat = n_stat; m_out = n_out; m_pend = n_pend; m_rst = n_rst;
    endtask

    task automatic cmd(string tag, int v);  step(tag, 1, 1, v, 0, 0); endtask
    task automatic dat(string tag, int v);  step(tag, 1, 0, v, 0, 0); endtask
    task automatic idle(string tag);        step(tag, 0, 0, 0, 0, 0); endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #200000;
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        m_mode = 'h03; m_stat = 'h18; m_out = 'h03; m_pend = 0; m_rst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "mode", int'(mode_o), 'h03);
        check("R1", "status", int'(status_o), 'h18);
        check("R1", "outport", int'(outport_o), 'h03);
        check("R1", "a20", int'(a20_o), 1);
        check("R1", "sys_rst", int'(sys_rst_o), 0);
        chk_en = 1'b1;
        dat("R1", 'h33);          // nothing armed after reset -> keyboard
        // R2 reply commands
        cmd("R2", 'h20); cmd("R2", 'hAA); cmd("R2", 'hA9);
        cmd("R2", 'hAB); cmd("R2", 'hC0); cmd("R2", 'hD0);
        // R6 mode bit commands
        cmd("R6", 'hA7); cmd("R6", 'hAD); cmd("R6", 'h20);
        cmd("R6", 'hA8); cmd("R6", 'hAE);
        // R3 two-phase mode write
        cmd("R3", 'h60); dat("R3", 'h47); cmd("R6", 'h20);
        // R4 unarmed data
        dat("R4", 'h12); dat("R4", 'hFE);
        // R5 armed data paths
        cmd("R5", 'hD2); dat("R5", 'h9A);
        cmd("R5", 'hD3); dat("R5", 'h5B);
        cmd("R5", 'hD4); dat("R5", 'hE8);
        // R7 gate control
        cmd("R7", 'hDD); cmd("R7", 'hD0); cmd("R7", 'hDF); idle("R7");
        // R8 output port writes
        cmd("R8", 'hD1); dat("R8", 'h02); idle("R11"); idle("R11");
        step("R8", 0, 0, 0, 1, 'h03); step("R8", 0, 0, 0, 1, 'h00); idle("R11");
        step("R8", 0, 0, 0, 1, 'h03);
        cmd("R8", 'hD1); step("R8", 1, 0, 'h01, 1, 'h03); idle("R8");
        // R9 remap
        cmd("R9", 'hF1); idle("R9"); cmd("R9", 'hFE); idle("R9");
        cmd("R9", 'hF0); cmd("R9", 'hF6); idle("R9"); cmd("R9", 'hFF); idle("R9");
        // R10 unknown codes and preserved arming
        cmd("R10", 'h55); cmd("R10", 'h00); cmd("R10", 'hB3); idle("R10");
        cmd("R10", 'h60); cmd("R10", 'h20); cmd("R10", 'h77);
        dat("R10", 'h01); cmd("R10", 'h20); dat("R10", 'h44);
        // R11 back-to-back requests give one pulse each
        cmd("R11", 'hFE); idle("R11"); cmd("R11", 'hFE); cmd("R11", 'hFE); idle("R11");
        idle("R11");
        finish_run();
    end
endmodule